// File: doc/BRIEF.md
# Radix-2^2 Delay-Feedback Butterfly Pair

This block is the front half of one radix-2^2 stage in a streaming, single-path FFT pipeline. Complex samples arrive one per accepted cycle, in natural order inside frames of N samples. It passes them through two butterflies. The first butterfly pairs samples N/2 apart and uses an N/2-word feedback line. The second pairs samples N/4 apart and uses an N/4-word feedback line. Between the two butterflies sits a fixed rotation by -j. It needs no multiplier, only a swap of the real and imaginary parts and one negation. The output stream goes to the general twiddle multiplier of the stage. Frames follow each other with no idle slots.

A single frame counter, advanced by each accepted sample, steers both butterflies and the rotation. For the first N/2 samples of each frame, a butterfly parks its input in the feedback line and sends out the differences it stored during the previous frame. For the next N/2 samples it emits sums and writes the differences back into the line. `inValid` may drop at any time. A cycle without it freezes the whole pipeline. A parameter selects the word growth: each adder either widens its result by one bit or keeps the width and halves the result.

Top module: `r22_butterfly_pair`

## Requirements
- R1: While `rst` is high and in the cycle after, `outValid` is 0 and `outRe`/`outIm` are 0.
- R2: Number the accepted samples from 0 after reset. Sample k belongs to frame k div N at position k mod N. Inside a frame, the first butterfly's result z(p) is (x(p)+x(p+N/2)) for p < N/2 and (x(p−N/2)−x(p)) for p ≥ N/2.
- R3: For p in [3N/4, N), z(p) is rotated by −j before the second butterfly: the new real part is the old imaginary part, and the new imaginary part is the negated old real part.
- R4: Output m belongs to frame m div N at position q = m mod N. Let h = q div (N/2), r = q mod (N/2) and b = h·N/2. Then y(q) = z(b+r)+z(b+r+N/4) for r < N/4, and y(q) = z(b+r−N/4)−z(b+r) otherwise.
- R5: Once the pipeline is full, each accepted sample produces exactly one output with `outValid` high in the next cycle. Outputs come in index order, and output frame f depends only on input frame f.
- R6: `outValid` stays low until 3N/4+2 samples have been accepted. It first rises in the cycle after that sample.
- R7: A cycle with `inValid` low changes no state. It is followed by a cycle with `outValid` low and `outRe`/`outIm` unchanged, whatever the data inputs carry.
- R8: With `SCALE`=0 the outputs are DW+2 bits wide and every sum and difference is exact, for all input values.
- R9: With `SCALE`=1 the outputs are DW bits wide. Every sum and difference is shifted right arithmetically by one bit (floor of half). The negation in the rotation wraps in two's complement at the first butterfly's width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample present; advances the pipeline |
| inRe | input | DW | Real part of input sample, two's complement |
| inIm | input | DW | Imaginary part of input sample, two's complement |
| outValid | output | 1 | Output sample present |
| outRe | output | OW | Real part of output (OW = DW+2, or DW when SCALE=1) |
| outIm | output | OW | Imaginary part of output |

## Verification
The bench builds two copies with N=16 and 8-bit data, one growing and one halving, and drives both from one stimulus. N=16 gives feedback lines of 8 and 4 words. Every counter phase, including the rotated quarter and the wrap from one frame to the next, therefore recurs many times within a few hundred cycles. Full-scale inputs at the 8-bit limits reach the widest growth of the growing copy and the negation wrap of the halving copy. Random gaps in `inValid` exercise the frozen pipeline.

// File: rtl/r22_pair_pkg.sv
package r22_pair_pkg;

  // Strobes from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic step;   // accepted sample: every register advances
    logic sel1;   // first butterfly computes (1) or loads (0)
    logic sel2;   // second butterfly computes (1) or loads (0)
    logic rot;    // rotate the second butterfly's input by -j
  } r22_strobe_t;

endpackage

// File: rtl/r22_fb_unit.sv
// One radix-2 butterfly with its feedback delay line.
module r22_fb_unit #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 9,
  parameter bit SCALE = 1'b0,
  parameter int DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic                    sel,
  input  logic signed [IN_W-1:0]  inRe,
  input  logic signed [IN_W-1:0]  inIm,
  output logic signed [OUT_W-1:0] outRe,
  output logic signed [OUT_W-1:0] outIm
);

  localparam int SUM_W = OUT_W + 1;

  logic signed [OUT_W-1:0] lineRe [DEPTH];
  logic signed [OUT_W-1:0] lineIm [DEPTH];
  logic signed [OUT_W-1:0] tailRe, tailIm;
  logic signed [OUT_W-1:0] pushRe, pushIm;
  logic signed [SUM_W-1:0] sumRe, sumIm, difRe, difIm;
  logic signed [OUT_W-1:0] sumReQ, sumImQ, difReQ, difImQ;

  assign tailRe = lineRe[DEPTH-1];
  assign tailIm = lineIm[DEPTH-1];

  // Full-width sum and difference of the parked sample and the new one.
  assign sumRe = SUM_W'(tailRe) + SUM_W'(inRe);
  assign sumIm = SUM_W'(tailIm) + SUM_W'(inIm);
  assign difRe = SUM_W'(tailRe) - SUM_W'(inRe);
  assign difIm = SUM_W'(tailIm) - SUM_W'(inIm);

  // Word growth policy: keep the low bits, or drop the LSB (floor halving).
  generate
    if (SCALE) begin : g_half
      assign sumReQ = sumRe[SUM_W-1:1];
      assign sumImQ = sumIm[SUM_W-1:1];
      assign difReQ = difRe[SUM_W-1:1];
      assign difImQ = difIm[SUM_W-1:1];
    end else begin : g_grow
      assign sumReQ = sumRe[OUT_W-1:0];
      assign sumImQ = sumIm[OUT_W-1:0];
      assign difReQ = difRe[OUT_W-1:0];
      assign difImQ = difIm[OUT_W-1:0];
    end
  endgenerate

  // Load phase: park the input, release stored differences.
  // Compute phase: emit the sum, feed the difference back.
  always_comb begin
    if (sel) begin
      pushRe = difReQ;
      pushIm = difImQ;
      outRe  = sumReQ;
      outIm  = sumImQ;
    end else begin
      pushRe = OUT_W'(inRe);
      pushIm = OUT_W'(inIm);
      outRe  = tailRe;
      outIm  = tailIm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) begin
        lineRe[k] <= '0;
        lineIm[k] <= '0;
      end
    end else if (step) begin
      lineRe[0] <= pushRe;
      lineIm[0] <= pushIm;
      for (int k = 1; k < DEPTH; k++) begin
        lineRe[k] <= lineRe[k-1];
        lineIm[k] <= lineIm[k-1];
      end
    end
  end

endmodule

// File: rtl/r22_pair_ctrl.sv
// Frame counter and strobe generation.
module r22_pair_ctrl
  import r22_pair_pkg::*;
#(
  parameter int LOG2N = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output r22_strobe_t strobe,
  output logic        outValid
);

  localparam int N    = 1 << LOG2N;
  localparam int HALF = N / 2;
  localparam int FILL = 3 * N / 4 + 1;
  localparam int CW   = LOG2N + 1;

  logic [LOG2N-1:0] frameCnt;  // position of the sample now at the input
  logic [LOG2N-1:0] midPos;    // frame position of the word between butterflies
  logic [CW-1:0]    fillCnt;   // accepted samples, saturating at FILL

  always_ff @(posedge clk) begin
    if (rst) begin
      frameCnt <= '0;
      midPos   <= '0;
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid && (fillCnt == CW'(FILL));
      if (inValid) begin
        frameCnt <= frameCnt + LOG2N'(1);
        // The first butterfly's output trails its input by half a frame.
        midPos   <= frameCnt ^ LOG2N'(HALF);
        if (fillCnt != CW'(FILL)) fillCnt <= fillCnt + CW'(1);
      end
    end
  end

  always_comb begin
    strobe.step = inValid;
    strobe.sel1 = frameCnt[LOG2N-1];
    strobe.sel2 = midPos[LOG2N-2];
    strobe.rot  = midPos[LOG2N-1] & midPos[LOG2N-2];
  end

endmodule

// File: rtl/r22_pair_datapath.sv
// Two feedback butterflies with the -j swap between them.
module r22_pair_datapath
  import r22_pair_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int DW    = 8,
  parameter bit SCALE = 1'b0,
  localparam int W1   = SCALE ? DW : DW + 1,
  localparam int W2   = SCALE ? DW : DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  r22_strobe_t          strobe,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic signed [W2-1:0] outRe,
  output logic signed [W2-1:0] outIm
);

  localparam int N = 1 << LOG2N;

  logic signed [W1-1:0] s1Re, s1Im;
  logic signed [W1-1:0] midRe, midIm;
  logic signed [W1-1:0] rotRe, rotIm;
  logic signed [W2-1:0] s2Re, s2Im;

  r22_fb_unit #(
    .IN_W(DW), .OUT_W(W1), .SCALE(SCALE), .DEPTH(N / 2)
  ) u_bfFirst (
    .clk(clk), .rst(rst), .step(strobe.step), .sel(strobe.sel1),
    .inRe(inRe), .inIm(inIm), .outRe(s1Re), .outIm(s1Im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      midRe <= '0;
      midIm <= '0;
    end else if (strobe.step) begin
      midRe <= s1Re;
      midIm <= s1Im;
    end
  end

  // Multiply by -j: (a + jb)(-j) = b - ja.
  always_comb begin
    if (strobe.rot) begin
      rotRe = midIm;
      rotIm = -midRe;
    end else begin
      rotRe = midRe;
      rotIm = midIm;
    end
  end

  r22_fb_unit #(
    .IN_W(W1), .OUT_W(W2), .SCALE(SCALE), .DEPTH(N / 4)
  ) u_bfSecond (
    .clk(clk), .rst(rst), .step(strobe.step), .sel(strobe.sel2),
    .inRe(rotRe), .inIm(rotIm), .outRe(s2Re), .outIm(s2Im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outRe <= '0;
      outIm <= '0;
    end else if (strobe.step) begin
      outRe <= s2Re;
      outIm <= s2Im;
    end
  end

endmodule

// File: rtl/r22_butterfly_pair.sv
module r22_butterfly_pair
  import r22_pair_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int DW    = 8,
  parameter bit SCALE = 1'b0,
  localparam int OW   = SCALE ? DW : DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic                 outValid,
  output logic signed [OW-1:0] outRe,
  output logic signed [OW-1:0] outIm
);

  r22_strobe_t strobe;

  r22_pair_ctrl #(.LOG2N(LOG2N)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  r22_pair_datapath #(.LOG2N(LOG2N), .DW(DW), .SCALE(SCALE)) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inRe(inRe), .inIm(inIm), .outRe(outRe), .outIm(outIm)
  );

endmodule

// File: rtl/r22_pair_chk.sv
module r22_pair_chk #(
  parameter int LOG2N = 4,
  parameter int OW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic          outValid,
  input logic [OW-1:0] outRe,
  input logic [OW-1:0] outIm
);

  localparam int N    = 1 << LOG2N;
  localparam int FILL = 3 * N / 4 + 1;
  localparam int CW   = LOG2N + 1;

  logic [CW-1:0] seen;  // accepted samples, saturating

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (inValid && seen != CW'(FILL)) seen <= seen + CW'(1);
  end

  // R6
  fill_gap_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($past(seen) == CW'(FILL)));

  // R5
  stream_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && seen == CW'(FILL)) |=> outValid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outRe) && $stable(outIm)));

  // R7
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

endmodule

bind r22_butterfly_pair r22_pair_chk #(.LOG2N(LOG2N), .OW(OW)) u_pairChk (
  .clk(clk), .rst(rst), .inValid(inValid),
  .outValid(outValid), .outRe(outRe), .outIm(outIm)
);

// File: tb/r22_butterfly_pair_bench.sv
module r22_butterfly_pair_bench;

  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int HALF  = N / 2;
  localparam int QTR   = N / 4;
  localparam int DW    = 8;
  localparam int FILL  = 3 * N / 4 + 1;
  localparam int OWG   = DW + 2;
  localparam int OWS   = DW;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic                 rst;
  logic                 inValid;
  logic signed [DW-1:0] inRe, inIm;
  logic                 gValid, sValid;
  logic signed [OWG-1:0] gRe, gIm;
  logic signed [OWS-1:0] sRe, sIm;

  r22_butterfly_pair #(.LOG2N(LOG2N), .DW(DW), .SCALE(1'b0)) u_r22_butterfly_pair (
    .clk(clk), .rst(rst), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(gValid), .outRe(gRe), .outIm(gIm)
  );

  r22_butterfly_pair #(.LOG2N(LOG2N), .DW(DW), .SCALE(1'b1)) u_r22_butterfly_pair_scaled (
    .clk(clk), .rst(rst), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(sValid), .outRe(sRe), .outIm(sIm)
  );

  int xsRe[$];
  int xsIm[$];
  int accepted = 0;
  int outIdxG = 0, outIdxS = 0;
  int checks = 0, fails = 0;
  int prevGRe = 0, prevGIm = 0, prevSRe = 0, prevSIm = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wrapTo(int v, int w);
    int m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m -= (1 << w);
    return m;
  endfunction

  function automatic int halve(int v, bit sc);
    return sc ? (v >>> 1) : v;
  endfunction

  // First butterfly result, with the -j rotation for the last quarter (R2, R3).
  function automatic void zAt(int g, bit sc, int w1, output int zr, output int zi);
    int b = (g / N) * N;
    int p = g % N;
    int t;
    if (p < HALF) begin
      zr = halve(xsRe[b+p] + xsRe[b+p+HALF], sc);
      zi = halve(xsIm[b+p] + xsIm[b+p+HALF], sc);
    end else begin
      zr = halve(xsRe[b+p-HALF] - xsRe[b+p], sc);
      zi = halve(xsIm[b+p-HALF] - xsIm[b+p], sc);
    end
    if (p >= 3 * QTR) begin
      t  = zr;
      zr = zi;
      zi = wrapTo(-t, w1);
    end
  endfunction

  // Second butterfly result for output index m (R4).
  function automatic void yAt(int m, bit sc, int w1, output int yr, output int yi);
    int q = m % N;
    int base = (m / N) * N + (q / HALF) * HALF;
    int r = q % HALF;
    int ar, ai, br, bi;
    if (r < QTR) begin
      zAt(base + r, sc, w1, ar, ai);
      zAt(base + r + QTR, sc, w1, br, bi);
      yr = halve(ar + br, sc);
      yi = halve(ai + bi, sc);
    end else begin
      zAt(base + r - QTR, sc, w1, ar, ai);
      zAt(base + r, sc, w1, br, bi);
      yr = halve(ar - br, sc);
      yi = halve(ai - bi, sc);
    end
  endfunction

  function automatic string posTag(int m);
    int q = m % N;
    if (q >= HALF) return "R3";
    if ((q % HALF) < QTR) return "R2";
    return "R4";
  endfunction

  // Monitor: samples one time unit after each rising edge.
  always @(posedge clk) begin
    bit step;
    bit expV;
    int er, ei;
    string vtag;
    #1;
    step = inValid && !rst;
    if (rst) begin
      check(!gValid && gRe == 0 && gIm == 0, "R1", "grow outputs in reset", int'(gRe), 0);
      check(!sValid && sRe == 0 && sIm == 0, "R1", "scaled outputs in reset", int'(sRe), 0);
    end else if (!finished) begin
      expV = step && (accepted >= FILL);
      vtag = !step ? "R7" : (accepted < FILL ? "R6" : "R5");
      check(gValid == expV, vtag, "grow outValid", int'(gValid), int'(expV));
      check(sValid == expV, vtag, "scaled outValid", int'(sValid), int'(expV));
      if (!step) begin
        check(int'(gRe) == prevGRe && int'(gIm) == prevGIm, "R7", "grow hold", int'(gRe), prevGRe);
        check(int'(sRe) == prevSRe && int'(sIm) == prevSIm, "R7", "scaled hold", int'(sRe), prevSRe);
      end
      if (gValid && expV) begin
        yAt(outIdxG, 1'b0, DW + 1, er, ei);
        check(int'(gRe) == er, {posTag(outIdxG), " R8"}, "grow re", int'(gRe), er);
        check(int'(gIm) == ei, {posTag(outIdxG), " R8"}, "grow im", int'(gIm), ei);
        outIdxG++;
      end
      if (sValid && expV) begin
        yAt(outIdxS, 1'b1, DW, er, ei);
        check(int'(sRe) == er, {posTag(outIdxS), " R9"}, "scaled re", int'(sRe), er);
        check(int'(sIm) == ei, {posTag(outIdxS), " R9"}, "scaled im", int'(sIm), ei);
        outIdxS++;
      end
      if (step) begin
        xsRe.push_back(int'(inRe));
        xsIm.push_back(int'(inIm));
        accepted++;
      end
    end
    prevGRe = int'(gRe);
    prevGIm = int'(gIm);
    prevSRe = int'(sRe);
    prevSIm = int'(sIm);
  end

  function automatic int sampleRe(int kind, int n);
    case (kind)
      0: return (n == 0) ? 50 : 0;
      1: return 100;
      2: return n * 15 - 120;
      3: return n[0] ? 127 : -128;
      4: return (n < HALF) ? -128 : 127;
      5: return int'($urandom_range(0, 255)) - 128;
      6: return -128;
      default: return 0;
    endcase
  endfunction

  function automatic int sampleIm(int kind, int n);
    case (kind)
      0: return (n == 0) ? -20 : 0;
      1: return -30;
      2: return 60 - n * 7;
      3: return n[1] ? -128 : 127;
      4: return (n < HALF) ? -128 : 127;
      5: return int'($urandom_range(0, 255)) - 128;
      6: return -128;
      default: return 0;
    endcase
  endfunction

  // One frame of N accepted samples, with random idle cycles carrying junk (R7).
  task automatic sendFrame(int kind, int gapPct);
    for (int n = 0; n < N; n++) begin
      while (gapPct > 0 && int'($urandom_range(0, 99)) < gapPct) begin
        @(negedge clk);
        inValid = 1'b0;
        inRe = DW'($urandom_range(0, 255));
        inIm = DW'($urandom_range(0, 255));
      end
      @(negedge clk);
      inValid = 1'b1;
      inRe = DW'(sampleRe(kind, n));
      inIm = DW'(sampleIm(kind, n));
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    inValid = 1'b0;
    inRe = '0;
    inIm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sendFrame(0, 0);
    sendFrame(1, 0);
    sendFrame(2, 0);
    sendFrame(3, 0);
    sendFrame(4, 0);
    sendFrame(6, 0);
    for (int i = 0; i < 3; i++) sendFrame(5, 30);
    sendFrame(2, 50);
    sendFrame(4, 20);
    sendFrame(7, 0);
    sendFrame(7, 0);
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    // R5: every sample past the fill point produced one output.
    check(outIdxG == accepted - FILL, "R5", "grow output count", outIdxG, accepted - FILL);
    check(outIdxS == accepted - FILL, "R5", "scaled output count", outIdxS, accepted - FILL);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    finishRun();
  end

endmodule